// File: doc/BRIEF.md
# AES-128 Round Key Expander

This block turns a 128-bit cipher key into the eleven 128-bit round keys that an AES-128 encryption datapath consumes, one key per clock. A single start strobe loads the cipher key; on the following eleven consecutive cycles the block presents round keys 0 through 10, each tagged with its round number and a valid strobe. After the last key, a done flag rises and stays high until the next start is accepted.

Internally the schedule runs as a recursion on 32-bit words. Only the current four-word group is held in a register, and the next group is derived from it in one cycle. The nonlinear word function rotates the last word of the group by one byte and substitutes each byte through an S-box. Four S-box instances compute the field inverse and affine map arithmetically, so there is no lookup table. The round constant is kept in a register and advanced by doubling in GF(2^8), with reduction polynomial 0x11B.

Top module: `aes128_keysched`

## Requirements
- R1: While reset is held low and in the first cycle after it is released, `rkey_vld_o` and `done_o` are 0 and `rkey_idx_o` is 0.
- R2: A start accepted at a rising edge (`start_i` high while `rkey_vld_o` is low) makes the block present `rkey_o` equal to the `key_i` sampled at that edge, with `rkey_idx_o` = 0 and `rkey_vld_o` = 1, from that edge on.
- R3: After an accepted start, `rkey_vld_o` stays high for exactly 11 consecutive cycles, and `rkey_idx_o` counts 0, 1, ..., 10 in those cycles.
- R4: The 128-bit output is four words. Bits [127:96] hold W[4i], [95:64] hold W[4i+1], [63:32] hold W[4i+2] and [31:0] hold W[4i+3]. Within a word, bits [31:24] are the leftmost byte. Each word other than W[4i] equals the word four places earlier XOR the word just before it.
- R5: W[4i] equals W[4i-4] XOR g(W[4i-1]). The function g rotates its input left by one byte, substitutes each byte through the AES S-box and XORs the round constant into the leftmost byte only.
- R6: The round constant for round key i (1..10) is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36. Each value is the previous one doubled in GF(2^8) modulo 0x11B.
- R7: One cycle after round key 10 is presented, `rkey_vld_o` falls and `done_o` rises. `done_o` stays high until the next start is accepted, and it is low from then on until that sequence ends.
- R8: `start_i` and `key_i` are ignored while `rkey_vld_o` is high, so the running sequence continues unchanged.
- R9: For the cipher key 2b7e151628aed2a6abf7158809cf4f3c, round key 1 is a0fafe1788542cb123a339392a6c7605 and round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6. For the all-zero key, round key 1 is 62636363 repeated four times and round key 10 is b4ef5bcb3e92e21123e951cf6f8f188e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Load `key_i` and begin a new schedule |
| key_i | input | 128 | Cipher key, leftmost byte in bits [127:120] |
| rkey_o | output | 128 | Current round key, W[4i] in bits [127:96] |
| rkey_idx_o | output | 4 | Round number of `rkey_o` |
| rkey_vld_o | output | 1 | High while `rkey_o` carries a round key of the running schedule |
| done_o | output | 1 | High from the end of a schedule until the next accepted start |

## Verification
The only state that carries from one round key to the next is the rolling four-word group and the round constant, so any corruption of either shows at the ports in the very next valid cycle. From then on it spreads through every later round key. A wrong round constant affects only the leftmost byte of W[4i] at first, but the XOR chain carries it into all four words of the same key in that cycle. A counter fault shows up as a wrong index, or as a valid window that is not exactly eleven cycles long. The bench compares all eleven keys for a spread of cipher keys against an arithmetic model. It also checks published round keys, and it pokes `start_i` in the middle of a run.

// File: rtl/aes_ks_pkg.sv
// Package aes_ks_pkg
// Shared widths and GF(2^8) arithmetic for the AES-128 round key expander.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package aes_ks_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 32;
    localparam int KEY_W     = 128;
    localparam int NUM_RKEYS = 11;
    localparam int WORDS     = KEY_W / WORD_W;
    localparam int BYTES_PW  = WORD_W / BYTE_W;
    localparam logic [BYTE_W-1:0] FIELD_RED  = 8'h1B;
    localparam logic [BYTE_W-1:0] AFFINE_C   = 8'h63;
    localparam logic [BYTE_W-1:0] RCON_FIRST = 8'h01;

    // Multiply by x in GF(2^8).
    function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? FIELD_RED : '0);
    endfunction

    // General multiply in GF(2^8), shift-and-add.
    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 (product of a^2, a^4, ..., a^128); zero maps to zero.
    function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a);
        logic [BYTE_W-1:0] sq;
        logic [BYTE_W-1:0] r;
        sq = a;
        r  = 8'h01;
        for (int i = 0; i < BYTE_W - 1; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    // Rotate a byte left by n places.
    function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] a, input int n);
        return (a << n) | (a >> (BYTE_W - n));
    endfunction
endpackage

// File: rtl/ks_sbox.sv
// Module ks_sbox
// Combinational AES forward S-box: field inverse followed by the affine map.
// Assumes no pipelining is wanted; the result settles within the cycle.
module ks_sbox
    import aes_ks_pkg::*;
(
    input  logic [BYTE_W-1:0] in_byte,
    output logic [BYTE_W-1:0] out_byte
);
    logic [BYTE_W-1:0] inv;

    // Invert in the field, then apply the rotate-XOR affine transform.
    always_comb begin
        inv      = gf_inv(in_byte);
        out_byte = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                 ^ rotl8(inv, 4) ^ AFFINE_C;
    end
endmodule

// File: rtl/ks_gword.sv
// Module ks_gword
// Nonlinear word function of the key schedule: byte rotate, per-byte
// substitution, round constant into the leftmost byte.
// Assumes byte 0 (leftmost) sits in the top bits of the word.
module ks_gword
    import aes_ks_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [BYTE_W-1:0] rcon_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] rot;
    logic [WORD_W-1:0] sub;

    // Rotate left by one byte: leftmost byte moves to the rightmost slot.
    always_comb rot = {word_i[WORD_W-BYTE_W-1:0], word_i[WORD_W-1 -: BYTE_W]};

    // One S-box per byte lane.
    for (genvar b = 0; b < BYTES_PW; b++) begin : g_lane
        ks_sbox u_sbox (
            .in_byte  (rot[b*BYTE_W +: BYTE_W]),
            .out_byte (sub[b*BYTE_W +: BYTE_W])
        );
    end

    // Round constant touches only the leftmost byte.
    always_comb word_o = sub ^ {rcon_i, {(WORD_W-BYTE_W){1'b0}}};
endmodule

// File: rtl/ks_rcon.sv
// Module ks_rcon
// Round constant register, advanced by field doubling.
// Assumes load and step are never high together.
module ks_rcon
    import aes_ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    output logic [BYTE_W-1:0] rcon_o
);
    logic [BYTE_W-1:0] rcon_q;

    // Reload to the first constant on start, double on every round step.
    always_ff @(posedge clk) begin
        if (!rst_n)      rcon_q <= RCON_FIRST;
        else if (load_i) rcon_q <= RCON_FIRST;
        else if (step_i) rcon_q <= gf_dbl(rcon_q);
    end

    assign rcon_o = rcon_q;
endmodule

// File: rtl/aes128_keysched.sv
// Module aes128_keysched
// AES-128 key expansion, one round key per cycle from a rolling four-word
// register. Assumes the consumer takes each key in the cycle it is valid;
// a start during a running schedule is ignored.
module aes128_keysched
    import aes_ks_pkg::*;
#(
    parameter int N_KEYS = NUM_RKEYS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [KEY_W-1:0]   key_i,
    output logic [KEY_W-1:0]   rkey_o,
    output logic [3:0]         rkey_idx_o,
    output logic               rkey_vld_o,
    output logic               done_o
);
    localparam int IDX_W = $clog2(N_KEYS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_KEYS - 1);

    logic [KEY_W-1:0]  rk_q;
    logic [KEY_W-1:0]  rk_next;
    logic [IDX_W-1:0]  idx_q;
    logic              vld_q;
    logic              done_q;
    logic              accept;
    logic              advance;
    logic [BYTE_W-1:0] rcon;
    logic [WORD_W-1:0] g_out;
    logic [WORD_W-1:0] cur_w [WORDS];
    logic [WORD_W-1:0] nxt_w [WORDS];

    // Decode start acceptance and round advance.
    always_comb begin
        accept  = start_i && !vld_q;
        advance = vld_q && (idx_q != LAST_IDX);
    end

    // Split the current group into words, W[4i] in the top bits.
    for (genvar w = 0; w < WORDS; w++) begin : g_split
        assign cur_w[w] = rk_q[KEY_W-1-w*WORD_W -: WORD_W];
    end

    ks_rcon u_rcon (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .step_i (advance),
        .rcon_o (rcon)
    );

    ks_gword u_gword (
        .word_i (cur_w[WORDS-1]),
        .rcon_i (rcon),
        .word_o (g_out)
    );

    // Word recursion: first word uses g, the rest chain on the new word before.
    always_comb begin
        nxt_w[0] = cur_w[0] ^ g_out;
        for (int w = 1; w < WORDS; w++) nxt_w[w] = cur_w[w] ^ nxt_w[w-1];
    end

    // Reassemble the next group.
    for (genvar w = 0; w < WORDS; w++) begin : g_join
        assign rk_next[KEY_W-1-w*WORD_W -: WORD_W] = nxt_w[w];
    end

    // Sequence control: load, step through rounds, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rk_q   <= '0;
            idx_q  <= '0;
            vld_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (accept) begin
            rk_q   <= key_i;
            idx_q  <= '0;
            vld_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (advance) begin
            rk_q   <= rk_next;
            idx_q  <= idx_q + 1'b1;
        end else if (vld_q) begin
            vld_q  <= 1'b0;
            done_q <= 1'b1;
        end
    end

    assign rkey_o     = rk_q;
    assign rkey_idx_o = 4'(idx_q);
    assign rkey_vld_o = vld_q;
    assign done_o     = done_q;
endmodule

// File: rtl/aes128_keysched_chk.sv
// Module aes128_keysched_chk
// Port-level protocol and recursion checks, bound into aes128_keysched.
// Assumes the default eleven-key configuration.
module aes128_keysched_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [127:0] key_i,
    input logic [127:0] rkey_o,
    input logic [3:0]   rkey_idx_o,
    input logic         rkey_vld_o,
    input logic         done_o
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rkey_vld_o && !done_o && rkey_idx_o == 4'd0));

    assert_first_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !rkey_vld_o) |=> (rkey_vld_o && rkey_idx_o == 4'd0 && rkey_o == $past(key_i)));

    assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rkey_vld_o && rkey_idx_o != 4'd10) |=> (rkey_vld_o && rkey_idx_o == $past(rkey_idx_o) + 4'd1));

    assert_word_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rkey_vld_o && rkey_idx_o != 4'd10) |=>
        (rkey_o[95:64] == ($past(rkey_o[95:64]) ^ rkey_o[127:96]) &&
         rkey_o[31:0]  == ($past(rkey_o[31:0])  ^ rkey_o[63:32])));

    assert_end_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rkey_vld_o && rkey_idx_o == 4'd10) |=> (!rkey_vld_o && done_o));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    assert_vld_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rkey_vld_o && done_o));

    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rkey_vld_o && rkey_idx_o != 4'd10 && start_i) |=> (rkey_idx_o != 4'd0));
endmodule

bind aes128_keysched aes128_keysched_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .key_i      (key_i),
    .rkey_o     (rkey_o),
    .rkey_idx_o (rkey_idx_o),
    .rkey_vld_o (rkey_vld_o),
    .done_o     (done_o)
);

// File: tb/aes128_keysched_bench.sv
module aes128_keysched_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [127:0] rkey_o;
    logic [3:0]   rkey_idx_o;
    logic         rkey_vld_o;
    logic         done_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [127:0] exp_rk [0:10];

    aes128_keysched u_aes128_keysched (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .rkey_o(rkey_o), .rkey_idx_o(rkey_idx_o), .rkey_vld_o(rkey_vld_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    // Reference arithmetic, written independently of the design.
    function automatic logic [7:0] m_dbl(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    endfunction
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = m_dbl(x);
        end
        return p;
    endfunction
    function automatic logic [7:0] m_sbox(input logic [7:0] a);
        logic [7:0] inv = 0;
        logic [7:0] s;
        for (int y = 1; y < 256; y++)
            if (a != 0 && m_mul(a, 8'(y)) == 8'h01) inv = 8'(y);
        for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i);
        return s;
    endfunction
    task automatic model(input logic [127:0] k);
        logic [31:0] w [0:43];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int j = 0; j < 4; j++) w[j] = k[127-32*j -: 32];
        for (int j = 4; j < 44; j++) begin
            t = w[j-1];
            if (j % 4 == 0) begin
                t = {m_sbox(t[23:16]) ^ rc, m_sbox(t[15:8]), m_sbox(t[7:0]), m_sbox(t[31:24])};
                rc = m_dbl(rc);
            end
            w[j] = w[j-4] ^ t;
        end
        for (int r = 0; r < 11; r++) exp_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one schedule; optionally poke start with a different key at round poke_at.
    task automatic run_key(input logic [127:0] k, input int poke_at);
        model(k);
        @(negedge clk);
        key_i = k; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R7 done cleared by start", {127'b0, done_o}, 128'd0);
        for (int i = 0; i < 11; i++) begin
            chk(rkey_vld_o == 1'b1, "R3 valid window", {127'b0, rkey_vld_o}, 128'd1);
            chk(rkey_idx_o == 4'(i), "R3 index", {124'b0, rkey_idx_o}, 128'(i));
            chk(rkey_o == exp_rk[i], (i == 0) ? "R2 first key" : "R4 R5 R6 round key", rkey_o, exp_rk[i]);
            if (i == poke_at) begin
                key_i = ~k; start_i = 1'b1;   // R8: must be ignored
                @(negedge clk);
                start_i = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk(rkey_vld_o == 1'b0, "R7 valid falls", {127'b0, rkey_vld_o}, 128'd0);
        chk(done_o == 1'b1, "R7 done rises", {127'b0, done_o}, 128'd1);
        repeat (2) @(negedge clk);
        chk(done_o == 1'b1, "R7 done holds", {127'b0, done_o}, 128'd1);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rkey_vld_o && !done_o && rkey_idx_o == 0, "R1 in reset", {126'b0, rkey_vld_o, done_o}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rkey_vld_o && !done_o && rkey_idx_o == 0, "R1 after reset", {126'b0, rkey_vld_o, done_o}, 128'd0);

        // R9 published vectors, checked on the ports.
        model(128'h2b7e151628aed2a6abf7158809cf4f3c);
        chk(exp_rk[10] == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R9 model sanity", exp_rk[10], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        run_key(128'h2b7e151628aed2a6abf7158809cf4f3c, -1);
        @(negedge clk); key_i = 128'h2b7e151628aed2a6abf7158809cf4f3c; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        chk(rkey_o == 128'ha0fafe1788542cb123a339392a6c7605, "R9 key1", rkey_o, 128'ha0fafe1788542cb123a339392a6c7605);
        repeat (9) @(negedge clk);
        chk(rkey_o == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R9 key10", rkey_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        repeat (2) @(negedge clk);

        run_key(128'h0, -1);
        chk(exp_rk[1] == {4{32'h62636363}}, "R9 zero key1", exp_rk[1], {4{32'h62636363}});
        chk(exp_rk[10] == 128'hb4ef5bcb3e92e21123e951cf6f8f188e, "R9 zero key10", exp_rk[10], 128'hb4ef5bcb3e92e21123e951cf6f8f188e);

        // Sweep of key patterns, with R8 start pokes at varying rounds.
        run_key({128{1'b1}}, 3);
        run_key(128'h000102030405060708090a0b0c0d0e0f, 0);
        run_key(128'h80000000000000000000000000000001, 9);
        for (int n = 0; n < 8; n++)
            run_key({4{32'h9e3779b9 * 32'(n + 1)}} ^ (128'h1 << (n * 13)), (n % 2 == 0) ? n : -1);
        report();
    end
endmodule